// File: doc/BRIEF.md
# Expansion Bus Master Takeover Controller

This block sits on the DMA-controller side of an expansion bus. It lets an add-on card take over the bus as its owner. A card starts the takeover the same way it would start an ordinary DMA transfer: it raises a request line on a channel that software has set to cascade operation. The block picks one such request and asks the host processor to release the bus. Once the host agrees, the block raises the channel's acknowledge and opens a window of a fixed number of bus clocks.

If the card raises its master-claim input inside that window, the block switches off its own address, command and data drivers. It also holds address-enable low, so I/O slaves decode the card's addresses. The card then owns the bus until it drops its request. At that point the block withdraws the acknowledge and leaves its drivers off for one more clock to avoid contention. It then drives the bus again and returns the bus to the host.

If the window runs out without a claim, the block withdraws the acknowledge and releases its request to the host. The data transfers the card performs while it owns the bus are outside this block, and so are normal DMA transfers.

Top module: `bus_master_handover`

## Requirements
- R1: A channel is eligible when both its `dreq` bit and its `cascade_en` bit are 1. From idle, the lowest-numbered eligible channel is taken, and `host_hold_req` goes to 1 in the cycle after the clock edge that samples the request.
- R2: A request on a channel whose `cascade_en` bit is 0 has no effect. `host_hold_req`, `dack` and `aen` stay 0 and `bus_drv_en` stays 1.
- R3: When `host_hold_ack` is sampled at 1 while the hold request is pending, exactly one `dack` bit goes to 1 in the next cycle. The bit position equals the channel index. `aen` is 1 for as long as the window is open.
- R4: If `card_master` is sampled at 1 at a clock edge while the window is open, then from the next cycle `bus_drv_en` is 0 and `aen` is 0, and `dack` stays asserted.
- R5: The window spans WINDOW clocks (default 4) of asserted `dack`. If no claim is sampled at the last of those edges, the next cycle shows `dack`, `aen` and `host_hold_req` at 0 and `bus_drv_en` at 1.
- R6: While the card owns the bus and keeps its request high, ownership persists whatever `card_master` does.
- R7: When the owning channel's request is sampled at 0, the next cycle shows `dack` at 0 while `bus_drv_en` stays 0 and `host_hold_req` stays 1. In the cycle after that, `bus_drv_en` is 1 and `host_hold_req` is 0.
- R8: If the selected channel's request drops while waiting for the host or inside the window, the block returns to idle in the next cycle without granting ownership.
- R9: `card_master` has no effect while the block is idle or waiting for the host.
- R10: While reset is active and right after it, `host_hold_req`, `dack` and `aen` are 0 and `bus_drv_en` is 1.
- R11: A claim sampled on the last window edge takes priority over expiry, and the card becomes the owner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cascade_en | input | NUM_CH | Per-channel cascade configuration |
| dreq | input | NUM_CH | Per-channel request lines from cards |
| host_hold_ack | input | 1 | Host agrees to give up the bus |
| card_master | input | 1 | Card claims bus ownership |
| host_hold_req | output | 1 | Request to the host to release the bus |
| dack | output | NUM_CH | Per-channel acknowledge, one-hot |
| aen | output | 1 | Address-enable, high while the window is open |
| bus_drv_en | output | 1 | Enable for this block's address, command and data drivers |

## Verification
Two events can land on the same clock edge: window expiry and the card's master claim on the final window clock. The bench provokes this directly by holding the claim low for the first WINDOW-1 edges of the window and raising it exactly on the last one. It then requires ownership (drivers off, acknowledge held), not cancellation. The random phase also drops requests on the same edges as claims. In that case the withdrawn request must win over the claim and the block must go back to idle. A reference model in the bench settles which outcome is expected on every cycle.

// File: rtl/bmh_pkg.sv
package bmh_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_HOLD    = 3'd1,
        ST_WINDOW  = 3'd2,
        ST_OWNED   = 3'd3,
        ST_RELEASE = 3'd4
    } bmh_state_e;

    typedef struct packed {
        logic hold_req;
        logic aen;
        logic drv_en;
        logic dack_on;
    } bmh_ctl_t;

    function automatic int idx_w(int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    function automatic bmh_ctl_t ctl_of(bmh_state_e s);
        bmh_ctl_t c;
        c.hold_req = (s != ST_IDLE);
        c.aen      = (s == ST_WINDOW);
        c.drv_en   = !((s == ST_OWNED) || (s == ST_RELEASE));
        c.dack_on  = (s == ST_WINDOW) || (s == ST_OWNED);
        return c;
    endfunction

endpackage

// File: rtl/bmh_req_select.sv
module bmh_req_select
    import bmh_pkg::*;
#(
    parameter int NUM_CH = 4,
    localparam int CH_W = idx_w(NUM_CH)
) (
    input  logic [NUM_CH-1:0] dreq,
    input  logic [NUM_CH-1:0] cascade_en,
    output logic              any_valid,
    output logic [CH_W-1:0]   sel_idx
);

    logic [NUM_CH-1:0] eligible;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_mask
        assign eligible[g] = dreq[g] & cascade_en[g];
    end

    assign any_valid = |eligible;

    // lowest index has priority
    always_comb begin
        sel_idx = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (eligible[i]) sel_idx = CH_W'(i);
        end
    end

endmodule

// File: rtl/bmh_window_timer.sv
module bmh_window_timer #(
    parameter int WINDOW = 4,
    localparam int CW = $clog2(WINDOW + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt != CW'(WINDOW - 1)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = run && (cnt == CW'(WINDOW - 1));

    p_count_advance_r5: assert property (@(posedge clk) disable iff (rst)
        (run && !expired) |=> (!run || (cnt == $past(cnt) + 1'b1)));

    p_fresh_window_r5: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt == '0));

endmodule

// File: rtl/bmh_owner_fsm.sv
module bmh_owner_fsm
    import bmh_pkg::*;
#(
    parameter int NUM_CH = 4,
    localparam int CH_W = idx_w(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              any_valid,
    input  logic [CH_W-1:0]   sel_idx,
    input  logic [NUM_CH-1:0] dreq,
    input  logic              host_ack,
    input  logic              master_in,
    input  logic              expired,
    output bmh_state_e        state,
    output logic [CH_W-1:0]   ch_q,
    output logic              sel_req
);

    bmh_state_e nxt;

    assign sel_req = dreq[ch_q];

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (any_valid) nxt = ST_HOLD;
            ST_HOLD: begin
                if (!sel_req)      nxt = ST_IDLE;
                else if (host_ack) nxt = ST_WINDOW;
            end
            ST_WINDOW: begin
                if (!sel_req)       nxt = ST_IDLE;
                else if (master_in) nxt = ST_OWNED;
                else if (expired)   nxt = ST_IDLE;
            end
            ST_OWNED:   if (!sel_req) nxt = ST_RELEASE;
            ST_RELEASE: nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            ch_q  <= '0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE && any_valid) ch_q <= sel_idx;
        end
    end

    p_release_single_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RELEASE) |=> (state == ST_IDLE));

    p_master_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_IDLE) || (state == ST_HOLD)) |=> (state != ST_OWNED));

    p_claim_wins_r11: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WINDOW && sel_req && master_in) |=> (state == ST_OWNED));

    p_drop_aborts_r8: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_HOLD || state == ST_WINDOW) && !sel_req) |=> (state == ST_IDLE));

    p_own_persist_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_OWNED && sel_req) |=> (state == ST_OWNED));

endmodule

// File: rtl/bus_master_handover.sv
module bus_master_handover
    import bmh_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int WINDOW = 4,
    localparam int CH_W = idx_w(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] cascade_en,
    input  logic [NUM_CH-1:0] dreq,
    input  logic              host_hold_ack,
    input  logic              card_master,
    output logic              host_hold_req,
    output logic [NUM_CH-1:0] dack,
    output logic              aen,
    output logic              bus_drv_en
);

    logic            any_valid;
    logic [CH_W-1:0] sel_idx;
    logic [CH_W-1:0] ch_q;
    logic            sel_req;
    logic            expired;
    bmh_state_e      state;
    bmh_ctl_t        ctl;

    bmh_req_select #(.NUM_CH(NUM_CH)) u_select (
        .dreq       (dreq),
        .cascade_en (cascade_en),
        .any_valid  (any_valid),
        .sel_idx    (sel_idx)
    );

    bmh_window_timer #(.WINDOW(WINDOW)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (state == ST_WINDOW),
        .expired (expired)
    );

    bmh_owner_fsm #(.NUM_CH(NUM_CH)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .any_valid (any_valid),
        .sel_idx   (sel_idx),
        .dreq      (dreq),
        .host_ack  (host_hold_ack),
        .master_in (card_master),
        .expired   (expired),
        .state     (state),
        .ch_q      (ch_q),
        .sel_req   (sel_req)
    );

    assign ctl           = ctl_of(state);
    assign host_hold_req = ctl.hold_req;
    assign aen           = ctl.aen;
    assign bus_drv_en    = ctl.drv_en;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_dack
        assign dack[g] = ctl.dack_on && (ch_q == CH_W'(g));
    end

    p_dack_onehot_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dack));

    p_dack_needs_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (|dack) |-> host_hold_req);

    p_owned_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        (!bus_drv_en && (|dack)) |-> !aen);

    p_noncascade_r2: assert property (@(posedge clk) disable iff (rst)
        (!host_hold_req && ((dreq & cascade_en) == '0)) |=> !host_hold_req);

    p_cancel_r5: assert property (@(posedge clk) disable iff (rst)
        (aen && expired && !card_master) |=> (!host_hold_req && bus_drv_en && dack == '0));

    p_release_gap_r7: assert property (@(posedge clk) disable iff (rst)
        (!bus_drv_en && (|dack) && !sel_req) |=> (!bus_drv_en && dack == '0 && host_hold_req));

    p_reset_idle_r10: assert property (@(posedge clk)
        $past(rst) |-> (!host_hold_req && bus_drv_en && !aen && dack == '0));

endmodule

// File: tb/bus_master_handover_bench.sv
module bus_master_handover_bench;

    localparam int NCH = 4;
    localparam int WIN = 4;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [NCH-1:0] cascade_en = '0;
    logic [NCH-1:0] dreq = '0;
    logic           host_hold_ack = 1'b0;
    logic           card_master = 1'b0;
    logic           host_hold_req;
    logic [NCH-1:0] dack;
    logic           aen;
    logic           bus_drv_en;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    // reference model: 0 idle, 1 wait host, 2 window, 3 owned, 4 release
    int ph = 0;
    int mch = 0;
    int mcnt = 0;

    always #4 clk = ~clk;

    bus_master_handover #(.NUM_CH(NCH), .WINDOW(WIN)) u_bus_master_handover (
        .clk           (clk),
        .rst           (rst),
        .cascade_en    (cascade_en),
        .dreq          (dreq),
        .host_hold_ack (host_hold_ack),
        .card_master   (card_master),
        .host_hold_req (host_hold_req),
        .dack          (dack),
        .aen           (aen),
        .bus_drv_en    (bus_drv_en)
    );

    function automatic int lowest(logic [NCH-1:0] v);
        for (int i = 0; i < NCH; i++) if (v[i]) return i;
        return -1;
    endfunction

    function automatic logic [NCH-1:0] exp_dack();
        return (ph == 2 || ph == 3) ? (NCH'(1) << mch) : '0;
    endfunction

    task automatic model_update();
        if (rst) begin
            ph = 0; mcnt = 0;
        end else begin
            case (ph)
                0: if ((dreq & cascade_en) != '0) begin ph = 1; mch = lowest(dreq & cascade_en); end
                1: if (!dreq[mch]) ph = 0; else if (host_hold_ack) begin ph = 2; mcnt = 0; end
                2: begin
                    if (!dreq[mch]) ph = 0;
                    else if (card_master) ph = 3;
                    else if (mcnt == WIN - 1) ph = 0;
                    else mcnt++;
                end
                3: if (!dreq[mch]) ph = 4;
                default: ph = 0;
            endcase
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic check_all(string tag);
        logic e_hold, e_aen, e_drv;
        logic [NCH-1:0] e_dack;
        e_hold = (ph != 0);
        e_aen  = (ph == 2);
        e_drv  = !(ph == 3 || ph == 4);
        e_dack = exp_dack();
        nchk++;
        if (host_hold_req !== e_hold || aen !== e_aen || bus_drv_en !== e_drv || dack !== e_dack) begin
            nfail++;
            $display("FAIL %s: hold=%b aen=%b drv=%b dack=%b expected hold=%b aen=%b drv=%b dack=%b",
                     tag, host_hold_req, aen, bus_drv_en, dack, e_hold, e_aen, e_drv, e_dack);
        end
    endtask

    task automatic check_val(string tag, logic [NCH-1:0] act, logic [NCH-1:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic to_idle();
        dreq = '0; card_master = 0; host_hold_ack = 0;
        step(); step();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        step(); step();
        check_all("R10 reset held");
        check_val("R10 drivers on in reset", NCH'(bus_drv_en), NCH'(1));
        rst = 0;
        step();
        check_all("R10 after reset");

        // R2 + R9: non-cascade requests, master toggling
        cascade_en = 4'b0101; dreq = 4'b1010;
        for (int i = 0; i < 5; i++) begin
            card_master = i[0];
            step();
            check_val("R2 non-cascade ignored", NCH'(host_hold_req), NCH'(0));
        end
        check_val("R9 drivers stay on", NCH'(bus_drv_en), NCH'(1));
        to_idle();

        // R1 priority, R3 grant, R4 takeover, R6 persist, R7 release
        cascade_en = 4'b1110; dreq = 4'b1100;
        step();
        check_val("R1 hold request raised", NCH'(host_hold_req), NCH'(1));
        card_master = 1;
        step();
        check_val("R9 master ignored while waiting", dack, 4'b0000);
        card_master = 0; host_hold_ack = 1;
        step();
        check_val("R3 dack lowest eligible bit 2", dack, 4'b0100);
        check_val("R3 aen in window", NCH'(aen), NCH'(1));
        host_hold_ack = 0;
        step();
        card_master = 1;
        step();
        check_val("R4 drivers off", NCH'(bus_drv_en), NCH'(0));
        check_val("R4 aen low", NCH'(aen), NCH'(0));
        check_val("R4 dack held", dack, 4'b0100);
        card_master = 0;
        for (int i = 0; i < 6; i++) step();
        check_all("R6 ownership persists");
        dreq = 4'b1000;
        step();
        check_val("R7 dack dropped", dack, 4'b0000);
        check_val("R7 drivers still off", NCH'(bus_drv_en), NCH'(0));
        check_val("R7 hold still up", NCH'(host_hold_req), NCH'(1));
        step();
        check_val("R7 drivers back on", NCH'(bus_drv_en), NCH'(1));
        check_val("R7 hold released", NCH'(host_hold_req), NCH'(0));
        to_idle();

        // R5 expiry
        cascade_en = 4'b0001; dreq = 4'b0001;
        step(); host_hold_ack = 1; step(); host_hold_ack = 0;
        for (int i = 0; i < WIN - 1; i++) step();
        check_val("R5 dack still up on last window clock", dack, 4'b0001);
        step();
        check_val("R5 dack withdrawn", dack, 4'b0000);
        check_all("R5 idle after expiry");
        to_idle();

        // R11 claim on last window edge
        dreq = 4'b0001;
        step(); host_hold_ack = 1; step(); host_hold_ack = 0;
        for (int i = 0; i < WIN - 1; i++) step();
        card_master = 1;
        step();
        check_val("R11 claim beats expiry", NCH'(bus_drv_en), NCH'(0));
        check_val("R11 dack held", dack, 4'b0001);
        to_idle();
        check_all("R7 idle after drop");

        // R8 drop while waiting and inside window
        dreq = 4'b0001;
        step();
        dreq = 4'b0000; host_hold_ack = 1;
        step();
        check_val("R8 drop while waiting", NCH'(host_hold_req), NCH'(0));
        host_hold_ack = 0; dreq = 4'b0001;
        step(); host_hold_ack = 1; step(); host_hold_ack = 0;
        dreq = 4'b0000; card_master = 1;
        step();
        check_val("R8 drop in window beats claim", dack, 4'b0000);
        check_all("R8 idle");
        to_idle();

        // random phase
        for (int n = 0; n < 3000; n++) begin
            for (int b = 0; b < NCH; b++) if (($urandom % 8) == 0) dreq[b] = ~dreq[b];
            if (($urandom % 32) == 0) cascade_en = NCH'($urandom);
            host_hold_ack = (($urandom % 2) == 0);
            card_master   = (($urandom % 4) == 0);
            step();
            case (ph)
                0: check_all("R2 random idle");
                1: check_all("R1 random waiting");
                2: check_all("R3 random window");
                3: check_all("R6 random owned");
                default: check_all("R7 random release");
            endcase
        end

        done = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule